// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer with Entry Locking

This block is a fully associative address translation cache. It has 64 slots, and each slot maps a virtual region to a physical region. A slot can hold a 4KB page, a 64KB page or a 1MB section. The tag compare ignores the low address bits that fall inside the slot's region. A 64KB page carries four permission fields, one for each 16KB quarter. This lets one slot cover the whole large page and still control access at a finer grain. With 64 slots, up to 256KB (all 4KB pages), 4MB (all 64KB pages) or 64MB (all sections) can be translated without a table walk.

The lookup port is purely combinational. It takes a virtual address, a read or write flag and a user or privileged flag. It returns hit, the physical address and a permission fault. An external walker writes a resolved mapping through the fill port. Control inputs do the following:
- pin a mapping so that it is never replaced;
- release all pins;
- flush every unpinned slot;
- flush the slots covering one address;
- flush the unpinned private slots of one process identifier.

Private slots hit only while the current identifier matches. Global slots hit for every identifier.

Top module: `tlb_top`

## Requirements
- R1: After reset every slot is empty: lookups miss and `fill_err_o` is low.
- R2: A slot compares virtual bits above bit 12 for size code 0 (4KB), above bit 16 for code 1 (64KB), and above bit 20 for codes 2 and 3 (1MB). On a hit, the physical address is the stored base above that bit, joined with the lookup address bits below it.
- R3: On a 64KB slot, lookup address bits [15:14] = q select permission field q, held in `fill_perm_i[2q+1:2q]`. 4KB and 1MB slots always use field 0.
- R4: The 2-bit permission code means: 0 = no access, 1 = privileged only, 2 = privileged full and user read-only, 3 = full access. `lk_fault_o` is high only on a hit that the selected code forbids.
- R5: A slot filled with `fill_global_i` low hits only while `cur_pid_i` equals the identifier that was current at fill. A global slot hits for any identifier.
- R6: A fill picks its victim by searching circularly from a rotating pointer. It takes the first empty slot; if there is none, it takes the first unpinned slot. The pointer then moves to the slot after the victim. Pinned slots are never victims.
- R7: If all 64 slots are pinned, a fill changes nothing and `fill_err_o` is high for exactly the following cycle.
- R8: `inval_all_i` empties every unpinned slot. Pinned slots stay valid and pinned.
- R9: `inval_pid_i` empties the unpinned, non-global slots whose identifier equals `inval_pid_val_i`.
- R10: `inval_va_i` empties every slot whose region covers `inval_addr_i`, whatever its identifier and even if it is pinned.
- R11: `unlock_all_i` clears every pin and leaves the mappings valid.
- R12: A fill first empties every valid slot that overlaps the new region at the coarser of the two sizes and shares its identifier (or where either one is global). Among matches, the lowest slot index wins.
- R13: A fill, pin or flush takes effect at the next rising clock edge. A lookup in the same cycle sees the old contents.
- R14: All 64 slots are usable: 64 disjoint 4KB fills are all resident at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_pid_i | input | 8 | Current process identifier |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_write_i | input | 1 | Lookup is a write |
| lk_user_i | input | 1 | Lookup is from user mode |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | 32 | Translated physical address |
| lk_fault_o | output | 1 | Permission fault on the hit |
| fill_i | input | 1 | Write a mapping |
| fill_va_i | input | 32 | Virtual base of the mapping |
| fill_pa_i | input | 32 | Physical base of the mapping |
| fill_size_i | input | 2 | Size code (0 4KB, 1 64KB, 2/3 1MB) |
| fill_perm_i | input | 8 | Four 2-bit permission fields |
| fill_global_i | input | 1 | Mapping ignores the identifier |
| fill_lock_i | input | 1 | Pin the new mapping |
| fill_err_o | output | 1 | Previous fill dropped, every slot pinned |
| unlock_all_i | input | 1 | Release all pins |
| inval_all_i | input | 1 | Flush unpinned slots |
| inval_va_i | input | 1 | Flush slots covering `inval_addr_i` |
| inval_addr_i | input | 32 | Address for the single flush |
| inval_pid_i | input | 1 | Flush private slots of one identifier |
| inval_pid_val_i | input | 8 | Identifier to flush |

## Verification
The assertions assume that a fill never arrives in the same cycle as a single-address flush, so that only overlap clearing or the address flush can empty a pinned slot. The stimulus keeps every operation in its own cycle. The one-hot match property assumes that slots are only written through the fill port, which clears overlaps first, and the bench has no other way to write a slot. Random traffic draws addresses from a small window so that different sizes collide often, and pins are rare so that full pinning comes only from a directed case.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W        = 32;
  localparam int PA_W        = 32;
  localparam int PID_W       = 8;
  localparam int PG_SHIFT    = 12;
  localparam int VPN_W       = VA_W - PG_SHIFT;
  localparam int PPN_W       = PA_W - PG_SHIFT;
  localparam int PERM_W      = 2;
  localparam int N_SUB       = 4;
  localparam int LARGE_SHIFT = 4;
  localparam int SECT_SHIFT  = 8;

  localparam logic [1:0] SZ_4K  = 2'd0;
  localparam logic [1:0] SZ_64K = 2'd1;

  typedef struct packed {
    logic                      valid;
    logic                      locked;
    logic                      glob;
    logic [PID_W-1:0]          pid;
    logic [1:0]                size;
    logic [VPN_W-1:0]          vpn;
    logic [PPN_W-1:0]          ppn;
    logic [N_SUB*PERM_W-1:0]   perm;
  } tlb_entry_t;

  function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
    case (sz)
      SZ_4K:   return '1;
      SZ_64K:  return {{(VPN_W-LARGE_SHIFT){1'b1}}, {LARGE_SHIFT{1'b0}}};
      default: return {{(VPN_W-SECT_SHIFT){1'b1}}, {SECT_SHIFT{1'b0}}};
    endcase
  endfunction

  function automatic logic [PPN_W-1:0] ppn_mask(input logic [1:0] sz);
    case (sz)
      SZ_4K:   return '1;
      SZ_64K:  return {{(PPN_W-LARGE_SHIFT){1'b1}}, {LARGE_SHIFT{1'b0}}};
      default: return {{(PPN_W-SECT_SHIFT){1'b1}}, {SECT_SHIFT{1'b0}}};
    endcase
  endfunction

  function automatic logic [1:0] coarser(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic perm_ok(input logic [1:0] p, input logic wr, input logic usr);
    case (p)
      2'd0:    return 1'b0;
      2'd1:    return !usr;
      2'd2:    return !usr || !wr;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_ENTRIES-1:0]                valid_i,
  input  logic [N_ENTRIES-1:0]                glob_i,
  input  logic [N_ENTRIES-1:0][PID_W-1:0]     pid_i,
  input  logic [N_ENTRIES-1:0][1:0]           size_i,
  input  logic [N_ENTRIES-1:0][VPN_W-1:0]     vpn_i,
  input  logic [PID_W-1:0]                    cur_pid_i,
  input  logic [VPN_W-1:0]                    lk_vpn_i,
  input  logic [VPN_W-1:0]                    iv_vpn_i,
  input  logic [VPN_W-1:0]                    fill_vpn_i,
  input  logic [1:0]                          fill_size_i,
  input  logic                                fill_global_i,
  output logic                                lk_hit_o,
  output logic [IDX_W-1:0]                    lk_idx_o,
  output logic [N_ENTRIES-1:0]                iv_vec_o,
  output logic [N_ENTRIES-1:0]                ov_vec_o
);
  logic [N_ENTRIES-1:0] lk_vec;

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
    logic [VPN_W-1:0] own_m, ov_m;
    logic             pid_ok, ov_pid;
    assign own_m  = vpn_mask(size_i[k]);
    assign ov_m   = vpn_mask(coarser(size_i[k], fill_size_i));
    assign pid_ok = glob_i[k] || (pid_i[k] == cur_pid_i);
    assign ov_pid = pid_ok || fill_global_i;
    assign lk_vec[k]   = valid_i[k] && pid_ok && (((vpn_i[k] ^ lk_vpn_i) & own_m) == '0);
    assign iv_vec_o[k] = valid_i[k] && (((vpn_i[k] ^ iv_vpn_i) & own_m) == '0);
    assign ov_vec_o[k] = valid_i[k] && ov_pid && (((vpn_i[k] ^ fill_vpn_i) & ov_m) == '0);
  end

  // lowest index wins
  always_comb begin
    lk_idx_o = '0;
    for (int k = N_ENTRIES - 1; k >= 0; k--) begin
      if (lk_vec[k]) lk_idx_o = IDX_W'(k);
    end
  end
  assign lk_hit_o = |lk_vec;

  AST_MATCH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec)); // R12
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [N_ENTRIES-1:0] lock_i,
  input  logic [IDX_W-1:0]     ptr_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic             got_free, got_open;
  logic [IDX_W-1:0] free_idx, open_idx, j;

  always_comb begin
    got_free = 1'b0;
    got_open = 1'b0;
    free_idx = '0;
    open_idx = '0;
    j        = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      j = ptr_i + IDX_W'(i);
      if (!got_free && !valid_i[j]) begin
        got_free = 1'b1;
        free_idx = j;
      end
      if (!got_open && !lock_i[j]) begin
        got_open = 1'b1;
        open_idx = j;
      end
    end
  end

  assign found_o = got_open;
  assign idx_o   = got_free ? free_idx : open_idx;

  AST_VICTIM_UNPINNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> !lock_i[idx_o]); // R6
  AST_PREFER_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !(&valid_i)) |-> !valid_i[idx_o]); // R6
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hit_i,
  input  logic [1:0]              size_i,
  input  logic [PPN_W-1:0]        ppn_i,
  input  logic [N_SUB*PERM_W-1:0] perm_i,
  input  logic [VA_W-1:0]         va_i,
  input  logic                    write_i,
  input  logic                    user_i,
  output logic [PA_W-1:0]         pa_o,
  output logic                    fault_o
);
  logic [1:0]       sub;
  logic [1:0]       code;
  logic [VPN_W-1:0] va_vpn;

  assign va_vpn  = va_i[VA_W-1:PG_SHIFT];
  assign sub     = (size_i == SZ_64K) ? va_i[PG_SHIFT+LARGE_SHIFT-1 -: 2] : 2'd0;
  assign code    = perm_i[sub*PERM_W +: PERM_W];
  assign fault_o = hit_i && !perm_ok(code, write_i, user_i);
  assign pa_o    = {(ppn_i & ppn_mask(size_i)) | PPN_W'(va_vpn & ~vpn_mask(size_i)),
                    va_i[PG_SHIFT-1:0]};

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_i); // R4
  AST_PAGE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (pa_o[PG_SHIFT-1:0] == va_i[PG_SHIFT-1:0])); // R2
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PID_W-1:0]        cur_pid_i,
  input  logic [VA_W-1:0]         lk_va_i,
  input  logic                    lk_write_i,
  input  logic                    lk_user_i,
  output logic                    lk_hit_o,
  output logic [PA_W-1:0]         lk_pa_o,
  output logic                    lk_fault_o,
  input  logic                    fill_i,
  input  logic [VA_W-1:0]         fill_va_i,
  input  logic [PA_W-1:0]         fill_pa_i,
  input  logic [1:0]              fill_size_i,
  input  logic [N_SUB*PERM_W-1:0] fill_perm_i,
  input  logic                    fill_global_i,
  input  logic                    fill_lock_i,
  output logic                    fill_err_o,
  input  logic                    unlock_all_i,
  input  logic                    inval_all_i,
  input  logic                    inval_va_i,
  input  logic [VA_W-1:0]         inval_addr_i,
  input  logic                    inval_pid_i,
  input  logic [PID_W-1:0]        inval_pid_val_i
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  tlb_entry_t ents_q [N_ENTRIES];
  tlb_entry_t ents_d [N_ENTRIES];
  tlb_entry_t new_ent;

  logic [N_ENTRIES-1:0]              valid_vec, lock_vec, glob_vec, iv_vec, ov_vec;
  logic [N_ENTRIES-1:0][PID_W-1:0]   pid_vec;
  logic [N_ENTRIES-1:0][1:0]         size_vec;
  logic [N_ENTRIES-1:0][VPN_W-1:0]   vpn_vec;
  logic [IDX_W-1:0]                  lk_idx, vic_idx, rr_q;
  logic                              vic_found, fill_go, err_q;

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_flat
    assign valid_vec[k] = ents_q[k].valid;
    assign lock_vec[k]  = ents_q[k].locked;
    assign glob_vec[k]  = ents_q[k].glob;
    assign pid_vec[k]   = ents_q[k].pid;
    assign size_vec[k]  = ents_q[k].size;
    assign vpn_vec[k]   = ents_q[k].vpn;
  end

  tlb_cam #(.N_ENTRIES(N_ENTRIES)) u_cam (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_vec),
    .glob_i        (glob_vec),
    .pid_i         (pid_vec),
    .size_i        (size_vec),
    .vpn_i         (vpn_vec),
    .cur_pid_i     (cur_pid_i),
    .lk_vpn_i      (lk_va_i[VA_W-1:PG_SHIFT]),
    .iv_vpn_i      (inval_addr_i[VA_W-1:PG_SHIFT]),
    .fill_vpn_i    (fill_va_i[VA_W-1:PG_SHIFT]),
    .fill_size_i   (fill_size_i),
    .fill_global_i (fill_global_i),
    .lk_hit_o      (lk_hit_o),
    .lk_idx_o      (lk_idx),
    .iv_vec_o      (iv_vec),
    .ov_vec_o      (ov_vec)
  );

  tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_vec),
    .lock_i  (lock_vec),
    .ptr_i   (rr_q),
    .found_o (vic_found),
    .idx_o   (vic_idx)
  );

  tlb_perm u_perm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (lk_hit_o),
    .size_i  (ents_q[lk_idx].size),
    .ppn_i   (ents_q[lk_idx].ppn),
    .perm_i  (ents_q[lk_idx].perm),
    .va_i    (lk_va_i),
    .write_i (lk_write_i),
    .user_i  (lk_user_i),
    .pa_o    (lk_pa_o),
    .fault_o (lk_fault_o)
  );

  assign fill_go = fill_i && vic_found;

  always_comb begin
    new_ent        = '0;
    new_ent.valid  = 1'b1;
    new_ent.locked = fill_lock_i;
    new_ent.glob   = fill_global_i;
    new_ent.pid    = cur_pid_i;
    new_ent.size   = fill_size_i;
    new_ent.vpn    = fill_va_i[VA_W-1:PG_SHIFT];
    new_ent.ppn    = fill_pa_i[PA_W-1:PG_SHIFT];
    new_ent.perm   = fill_perm_i;
  end

  // flushes act on old state; fill write lands last
  always_comb begin
    for (int k = 0; k < N_ENTRIES; k++) begin
      ents_d[k] = ents_q[k];
      if (inval_all_i && !ents_q[k].locked) ents_d[k].valid = 1'b0;
      if (inval_pid_i && !ents_q[k].glob && !ents_q[k].locked &&
          ents_q[k].pid == inval_pid_val_i) ents_d[k].valid = 1'b0;
      if (inval_va_i && iv_vec[k]) begin
        ents_d[k].valid  = 1'b0;
        ents_d[k].locked = 1'b0;
      end
      if (unlock_all_i) ents_d[k].locked = 1'b0;
      if (fill_go && ov_vec[k]) begin
        ents_d[k].valid  = 1'b0;
        ents_d[k].locked = 1'b0;
      end
      if (fill_go && vic_idx == IDX_W'(k)) ents_d[k] = new_ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_ENTRIES; k++) ents_q[k] <= '0;
      rr_q  <= '0;
      err_q <= 1'b0;
    end else begin
      for (int k = 0; k < N_ENTRIES; k++) ents_q[k] <= ents_d[k];
      if (fill_go) rr_q <= vic_idx + IDX_W'(1);
      err_q <= fill_i && !vic_found;
    end
  end

  assign fill_err_o = err_q;

  AST_FULL_PIN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && (&lock_vec)) |=> fill_err_o); // R7
  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_i && (&lock_vec)) |=> !fill_err_o); // R7
  AST_PIN_IMPLIES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_vec & ~valid_vec) == '0); // R8

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_chk
    AST_PIN_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_vec[k] && !inval_va_i && !fill_i) |=> valid_vec[k]); // R8
  end
endmodule

// File: tb/tb_tlb_top.sv
module tb_tlb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic [31:0] lk_va = '0;
  logic        lk_write = 1'b0, lk_user = 1'b0;
  logic        lk_hit, lk_fault, fill_err;
  logic [31:0] lk_pa;
  logic        fill = 1'b0;
  logic [31:0] fill_va = '0, fill_pa = '0;
  logic [1:0]  fill_size = '0;
  logic [7:0]  fill_perm = '0;
  logic        fill_global = 1'b0, fill_lock = 1'b0;
  logic        unlock_all = 1'b0, inval_all = 1'b0, inval_va = 1'b0, inval_pid = 1'b0;
  logic [31:0] inval_addr = '0;
  logic [7:0]  inval_pid_val = '0;

  int n_chk = 0, n_fail = 0;

  bit         m_v [N];
  bit         m_l [N];
  bit         m_g [N];
  bit [7:0]   m_pid [N];
  bit [1:0]   m_sz [N];
  bit [19:0]  m_vpn [N];
  bit [19:0]  m_ppn [N];
  bit [7:0]   m_perm [N];
  int         m_ptr = 0;
  bit         exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cur_pid_i(cur_pid),
    .lk_va_i(lk_va), .lk_write_i(lk_write), .lk_user_i(lk_user),
    .lk_hit_o(lk_hit), .lk_pa_o(lk_pa), .lk_fault_o(lk_fault),
    .fill_i(fill), .fill_va_i(fill_va), .fill_pa_i(fill_pa), .fill_size_i(fill_size),
    .fill_perm_i(fill_perm), .fill_global_i(fill_global), .fill_lock_i(fill_lock),
    .fill_err_o(fill_err), .unlock_all_i(unlock_all), .inval_all_i(inval_all),
    .inval_va_i(inval_va), .inval_addr_i(inval_addr), .inval_pid_i(inval_pid),
    .inval_pid_val_i(inval_pid_val)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog R13 act=running exp=finished");
    report();
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit [19:0] vmask(bit [1:0] s);
    case (s)
      2'd0: return 20'hFFFFF;
      2'd1: return 20'hFFFF0;
      default: return 20'hFFF00;
    endcase
  endfunction

  function automatic bit ok_code(bit [1:0] p, bit wr, bit usr);
    case (p)
      2'd0: return 0;
      2'd1: return !usr;
      2'd2: return !usr || !wr;
      default: return 1;
    endcase
  endfunction

  task automatic ref_lookup(bit [31:0] va, bit wr, bit usr,
                            output bit hit, output bit [31:0] pa, output bit flt);
    hit = 0; pa = '0; flt = 0;
    for (int k = 0; k < N; k++) begin
      if (!hit && m_v[k] && (m_g[k] || m_pid[k] == cur_pid) &&
          ((m_vpn[k] ^ va[31:12]) & vmask(m_sz[k])) == 0) begin
        bit [1:0] q;
        hit = 1;
        pa  = ({m_ppn[k], 12'h0} & {vmask(m_sz[k]), 12'h000}) |
              (va & ~{vmask(m_sz[k]), 12'h000});
        q   = (m_sz[k] == 2'd1) ? va[15:14] : 2'd0;
        flt = !ok_code(2'(m_perm[k] >> (2*q)), wr, usr);
      end
    end
  endtask

  task automatic check_lookup(bit [31:0] va, bit wr, bit usr, string req);
    bit h, f; bit [31:0] p;
    lk_va = va; lk_write = wr; lk_user = usr;
    #1;
    ref_lookup(va, wr, usr, h, p, f);
    chk({req, " hit"}, 64'(lk_hit), 64'(h));
    if (h) begin
      chk({req, " pa"}, 64'(lk_pa), 64'(p));
      chk({req, " fault"}, 64'(lk_fault), 64'(f));
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    fill = 0; unlock_all = 0; inval_all = 0; inval_va = 0; inval_pid = 0;
  endtask

  task automatic model_fill(bit [31:0] va, bit [31:0] pa, bit [1:0] sz, bit [7:0] pm,
                            bit g, bit lk);
    int j = -1;
    for (int i = 0; i < N; i++) if (j < 0 && !m_v[(m_ptr+i)%N]) j = (m_ptr+i)%N;
    for (int i = 0; i < N; i++) if (j < 0 && !m_l[(m_ptr+i)%N]) j = (m_ptr+i)%N;
    exp_err = (j < 0);
    if (j < 0) return;
    for (int k = 0; k < N; k++) begin
      bit [1:0] c = (m_sz[k] > sz) ? m_sz[k] : sz;
      if (m_v[k] && (m_g[k] || g || m_pid[k] == cur_pid) &&
          ((m_vpn[k] ^ va[31:12]) & vmask(c)) == 0) begin
        m_v[k] = 0; m_l[k] = 0;
      end
    end
    m_v[j] = 1; m_l[j] = lk; m_g[j] = g; m_pid[j] = cur_pid; m_sz[j] = sz;
    m_vpn[j] = va[31:12]; m_ppn[j] = pa[31:12]; m_perm[j] = pm;
    m_ptr = (j + 1) % N;
  endtask

  task automatic do_fill(bit [31:0] va, bit [31:0] pa, bit [1:0] sz, bit [7:0] pm,
                         bit g, bit lk);
    fill = 1; fill_va = va; fill_pa = pa; fill_size = sz; fill_perm = pm;
    fill_global = g; fill_lock = lk;
    step();
    model_fill(va, pa, sz, pm, g, lk);
    chk("R7 fill_err", 64'(fill_err), 64'(exp_err));
  endtask

  task automatic do_inval_all();
    inval_all = 1; step();
    for (int k = 0; k < N; k++) if (!m_l[k]) m_v[k] = 0;
  endtask

  task automatic do_unlock();
    unlock_all = 1; step();
    for (int k = 0; k < N; k++) m_l[k] = 0;
  endtask

  task automatic do_inval_va(bit [31:0] a);
    inval_va = 1; inval_addr = a; step();
    for (int k = 0; k < N; k++)
      if (m_v[k] && ((m_vpn[k] ^ a[31:12]) & vmask(m_sz[k])) == 0) begin
        m_v[k] = 0; m_l[k] = 0;
      end
  endtask

  task automatic do_inval_pid(bit [7:0] p);
    inval_pid = 1; inval_pid_val = p; step();
    for (int k = 0; k < N; k++)
      if (!m_g[k] && !m_l[k] && m_pid[k] == p) m_v[k] = 0;
  endtask

  function automatic bit [31:0] rand_va();
    return {10'h0, 22'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    #(CLK_PERIOD*2);
    rst_n = 1;
    #1;
    // R1
    chk("R1 hit after reset", 64'(lk_hit), 64'd0);
    chk("R1 err after reset", 64'(fill_err), 64'd0);
    step();

    // R2 sizes
    do_fill(32'h0001_2000, 32'h8000_0000, 2'd0, 8'hFF, 0, 0);
    check_lookup(32'h0001_2ABC, 0, 0, "R2 4K");
    chk("R2 4K pa literal", 64'(lk_pa), 64'h8000_0ABC);
    check_lookup(32'h0001_3000, 0, 0, "R2 4K neighbour");
    do_fill(32'h0012_0000, 32'h9005_0000, 2'd1, 8'hFF, 0, 0);
    check_lookup(32'h0012_F123, 0, 0, "R2 64K");
    chk("R2 64K pa literal", 64'(lk_pa), 64'h9005_F123);
    do_fill(32'h0050_0000, 32'hA030_0000, 2'd2, 8'hFF, 0, 0);
    check_lookup(32'h005A_BCDE, 0, 0, "R2 1M");
    chk("R2 1M pa literal", 64'(lk_pa), 64'hA03A_BCDE);

    // R3 subpage permissions on 64K: fields q=0..3 -> codes 0,1,2,3
    do_fill(32'h0200_0000, 32'h1000_0000, 2'd1, 8'b11_10_01_00, 0, 0);
    for (int q = 0; q < 4; q++) begin
      check_lookup(32'h0200_0000 | (q << 14), 1, 1, "R3 subpage user write");
      chk("R3 fault literal", 64'(lk_fault), 64'(q != 3));
    end
    // R4 encodings on a 4K page
    for (int c = 0; c < 4; c++) begin
      do_fill(32'h0300_0000 + (c << 12), 32'h2000_0000, 2'd0, 8'(c), 0, 0);
      for (int a = 0; a < 4; a++)
        check_lookup(32'h0300_0000 + (c << 12), a[0], a[1], "R4 perm code");
    end

    // R5 identifiers
    cur_pid = 8'd5;
    do_fill(32'h0400_0000, 32'h3000_0000, 2'd0, 8'hFF, 0, 0);
    do_fill(32'h0401_0000, 32'h3100_0000, 2'd0, 8'hFF, 1, 0);
    cur_pid = 8'd6;
    check_lookup(32'h0400_0000, 0, 0, "R5 other pid private");
    chk("R5 miss literal", 64'(lk_hit), 64'd0);
    check_lookup(32'h0401_0000, 0, 0, "R5 other pid global");
    chk("R5 global literal", 64'(lk_hit), 64'd1);
    cur_pid = 8'd5;
    check_lookup(32'h0400_0000, 0, 0, "R5 own pid");

    // R13 same-cycle fill and lookup
    fill = 1; fill_va = 32'h0600_0000; fill_pa = 32'h4000_0000; fill_size = 0;
    fill_perm = 8'hFF; fill_global = 0; fill_lock = 0;
    lk_va = 32'h0600_0010; #1;
    chk("R13 old state before edge", 64'(lk_hit), 64'd0);
    step();
    model_fill(32'h0600_0000, 32'h4000_0000, 0, 8'hFF, 0, 0);
    check_lookup(32'h0600_0010, 0, 0, "R13 after edge");
    chk("R13 hit literal", 64'(lk_hit), 64'd1);

    // R12 overlap replace
    do_fill(32'h0700_3000, 32'h5000_0000, 2'd0, 8'hFF, 0, 0);
    do_fill(32'h0700_0000, 32'h5100_0000, 2'd1, 8'hFF, 0, 0);
    check_lookup(32'h0700_3004, 0, 0, "R12 overlap");
    chk("R12 pa literal", 64'(lk_pa), 64'h5100_3004);

    // R9 pid flush
    do_inval_pid(8'd5);
    check_lookup(32'h0400_0000, 0, 0, "R9 private gone");
    check_lookup(32'h0401_0000, 0, 0, "R9 global kept");

    // R10 single flush including pinned
    do_fill(32'h0800_0000, 32'h6000_0000, 2'd2, 8'hFF, 1, 1);
    do_inval_va(32'h080F_F000);
    check_lookup(32'h0800_0000, 0, 0, "R10 pinned covered");

    // R8 flush all keeps pinned
    do_fill(32'h0900_0000, 32'h6100_0000, 2'd0, 8'hFF, 0, 1);
    do_inval_all();
    check_lookup(32'h0900_0000, 0, 0, "R8 pinned kept");
    check_lookup(32'h0001_2000, 0, 0, "R8 unpinned gone");

    // R14/R6/R7 capacity and full pinning
    do_unlock(); do_inval_all();
    for (int i = 0; i < N; i++)
      do_fill(32'h0A00_0000 + (i << 12), 32'h7000_0000 + (i << 12), 0, 8'hFF, 0, 1);
    for (int i = 0; i < N; i++)
      check_lookup(32'h0A00_0000 + (i << 12), 0, 0, "R14 resident");
    do_fill(32'h0B00_0000, 32'h7F00_0000, 0, 8'hFF, 0, 0);
    chk("R7 dropped literal", 64'(fill_err), 64'd1);
    check_lookup(32'h0B00_0000, 0, 0, "R7 dropped fill");
    step();
    chk("R7 one cycle", 64'(fill_err), 64'd0);
    do_unlock();
    check_lookup(32'h0A00_0000, 0, 0, "R11 valid after unpin");
    do_fill(32'h0B00_0000, 32'h7F00_0000, 0, 8'hFF, 0, 0);
    chk("R11 no err", 64'(fill_err), 64'd0);
    for (int i = 0; i < N; i++)
      check_lookup(32'h0A00_0000 + (i << 12), 0, 0, "R6 round robin victim");
    check_lookup(32'h0B00_0000, 0, 0, "R6 new entry");

    // random mix
    do_inval_all();
    for (int it = 0; it < 3000; it++) begin
      int r = $urandom % 16;
      if (r < 6)
        do_fill(rand_va(), $urandom, 2'($urandom % 3), 8'($urandom),
                ($urandom % 4) == 0, ($urandom % 16) == 0);
      else if (r == 6) do_inval_va(rand_va());
      else if (r == 7) do_inval_pid(8'($urandom % 3));
      else if (r == 8 && ($urandom % 4) == 0) do_inval_all();
      else if (r == 9) do_unlock();
      else if (r == 10) cur_pid = 8'($urandom % 3);
      else check_lookup(rand_va(), 1'($urandom), 1'($urandom), "R2 random");
    end

    report();
    $finish;
  end
endmodule